// File: doc/BRIEF.md
# Marker-Synchronised Manchester Identifier Decoder

This block takes a serial stream of already-demodulated bits, one bit per cycle that `bit_valid` is high, and pulls fixed-format identifiers out of it. It hunts for a six-bit sync pattern 1,1,1,0,0,0. After the pattern it reads the stream as two-bit Manchester symbols and shifts each decoded bit into a 96-bit identifier chain made of three 32-bit words. The payload ends at the first symbol whose two bits are equal. The identifier is published only if a complete sync pattern starts exactly at that symbol. That closing pattern also opens the next frame, so frames sent back to back are each reported.

The controller is a five-state machine. HUNT shifts every valid bit into a six-bit window and leaves on a pattern match (transition *sync found*, which clears the chain). PAIR_A stores the first bit of a symbol. PAIR_B either decodes the symbol (*decode*, back to PAIR_A), sees an equal 1,1 pair (*close start*, to CLOSE), or sees an equal 0,0 pair (*abort*, to HUNT). CLOSE checks the remaining four pattern bits. It goes to HUNT on a mismatch (*abort*), and on a full match (*report*) it goes to PAIR_A, or to HOLD in single-shot mode. HOLD ignores data and goes to HUNT on `rearm` (*rearm*). After an abort the search starts again from the symbol where decoding stopped, not from the next fresh bit.

Top module: `mfd_decoder`

## Requirements
- R1: While hunting, the sync pattern 1,1,1,0,0,0 (first bit received first) is tested on every valid bit. Only bits received at or after the current search start point count toward a match.
- R2: After sync, bits are taken in pairs. The pair 1,0 decodes to 0 and the pair 0,1 decodes to 1.
- R3: Each decoded bit enters bit 0 of the low word. Bit 31 of the low word moves to bit 0 of the middle word, and bit 31 of the middle word moves to bit 0 of the high word. Bits shifted out of the high word are lost.
- R4: A pair of equal bits ends the payload. The identifier is reported only if that pair and the next four bits together form the full sync pattern. A 0,0 pair or any mismatching bit produces no report.
- R5: The identifier chain is cleared at the start of every frame, so a report contains only that frame's bits.
- R6: A closing sync pattern that leads to a report also starts the next frame. Back-to-back frames are each reported.
- R7: After an aborted frame, the search for the sync pattern resumes at the first bit of the pair that ended decoding.
- R8: `id_valid` is high for exactly one cycle, in the cycle after the clock edge that took the final closing bit. `id_hi`, `id_mid` and `id_lo` hold the reported identifier until the next report.
- R9: `card_num` equals bits 16 down to 1 of `id_lo`. `short_fmt` is 1 exactly when `id_hi` is zero.
- R10: With `single_mode` high at the report, no further report occurs until `rearm` is pulsed. After `rearm` the search restarts fresh.
- R11: Cycles with `bit_valid` low do not advance decoding and have no effect on the result.
- R12: After reset all identifier outputs are zero, `id_valid` is 0, `short_fmt` is 1 and the block is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | `bit_in` carries a stream bit this cycle |
| bit_in | input | 1 | Stream bit |
| single_mode | input | 1 | Stop after the first report |
| rearm | input | 1 | Leave the stopped state and hunt again |
| id_hi | output | 32 | Reported identifier, upper word |
| id_mid | output | 32 | Reported identifier, middle word |
| id_lo | output | 32 | Reported identifier, low word |
| id_valid | output | 1 | One-cycle report strobe |
| short_fmt | output | 1 | Upper word of the report is zero |
| card_num | output | 16 | Bits 16:1 of `id_lo` |

## Verification
Table frames vary the payload length over 0, 1, 8, 17, 32, 40, 70 and 100 bits. These lengths separate the decode polarity, the carries into the middle and high words, the loss of bits beyond 96, and the card-number and short-format fields. Other table frames end in a 0,0 pair or in a broken closing pattern, which shows that a report needs the exact closer. Directed streams cover back-to-back frames, where the second identifier shows whether the chain was cleared and whether the closer restarted decoding. They also cover a failed closer whose last bits form a new sync pattern, which tells a search that resumes at the stop point from one that skips ahead. Idle gaps between bits, the exact strobe cycle, and single-shot mode with rearm are tested as well.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
    typedef enum logic [2:0] {
        ST_HUNT,
        ST_PAIR_A,
        ST_PAIR_B,
        ST_CLOSE,
        ST_HOLD
    } mfd_state_e;
endpackage

// File: rtl/mfd_window.sv
// Sync-pattern window: shifts every valid bit, tracks how many bits lie
// at or after the current search start point, and flags a match.
module mfd_window #(
    parameter int MARK_LEN = 6,
    parameter logic [MARK_LEN-1:0] MARK_PAT = 6'b111000,
    localparam int AGE_W = $clog2(MARK_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    input  logic             restart,
    input  logic [AGE_W-1:0] restart_age,
    output logic             hit
);
    logic [MARK_LEN-1:0] win_q;
    logic [MARK_LEN-1:0] win_nx;
    logic [AGE_W-1:0]    age_q;
    logic [AGE_W:0]      age_inc;

    assign win_nx  = {win_q[MARK_LEN-2:0], bit_in};
    assign age_inc = {1'b0, age_q} + 1'b1;
    assign hit     = shift_en && (win_nx == MARK_PAT) &&
                     (age_inc >= (AGE_W+1)'(MARK_LEN));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
            age_q <= '0;
        end else begin
            if (shift_en) begin
                win_q <= win_nx;
            end
            if (restart) begin
                age_q <= restart_age;
            end else if (shift_en && (age_inc <= (AGE_W+1)'(MARK_LEN))) begin
                age_q <= age_inc[AGE_W-1:0];
            end
        end
    end
endmodule

// File: rtl/mfd_idreg.sv
// Identifier shift chain: NUM_WORDS words, the MSB of each feeding the LSB
// of the next word up.
module mfd_idreg #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr,
    input  logic                             shift_en,
    input  logic                             bit_in,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] words
);
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        logic [WORD_W-1:0] word_q;
        logic              carry_in;

        if (g == 0) begin : g_first
            assign carry_in = bit_in;
        end else begin : g_next
            assign carry_in = words[g-1][WORD_W-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (clr) begin
                word_q <= '0;
            end else if (shift_en) begin
                word_q <= {word_q[WORD_W-2:0], carry_in};
            end
        end

        assign words[g] = word_q;
    end

    // R5: a clear request leaves the whole chain empty on the next cycle
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (words == '0));
endmodule

// File: rtl/mfd_decoder.sv
module mfd_decoder #(
    parameter int WORD_W   = 32,
    parameter int NUM_W    = 16,
    parameter int MARK_LEN = 6,
    parameter logic [MARK_LEN-1:0] MARK_PAT = 6'b111000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              single_mode,
    input  logic              rearm,
    output logic [WORD_W-1:0] id_hi,
    output logic [WORD_W-1:0] id_mid,
    output logic [WORD_W-1:0] id_lo,
    output logic              id_valid,
    output logic              short_fmt,
    output logic [NUM_W-1:0]  card_num
);
    import mfd_pkg::*;

    localparam int NUM_WORDS = 3;
    localparam int CHK_LEN   = MARK_LEN - 2;
    localparam int CHK_W     = (CHK_LEN > 1) ? $clog2(CHK_LEN) : 1;
    localparam int AGE_W     = $clog2(MARK_LEN + 1);

    mfd_state_e        state_q, state_nx;
    logic              first_q, first_nx;
    logic [CHK_W-1:0]  chk_q, chk_nx;
    logic              clr, dec_shift, restart, report, hit, exp_bit;
    logic [AGE_W-1:0]  restart_age;
    logic [NUM_WORDS-1:0][WORD_W-1:0] words;
    logic [NUM_WORDS-1:0][WORD_W-1:0] out_q;
    logic              valid_q;

    mfd_window #(.MARK_LEN(MARK_LEN), .MARK_PAT(MARK_PAT)) u_window (
        .clk(clk), .rst_n(rst_n), .shift_en(bit_valid), .bit_in(bit_in),
        .restart(restart), .restart_age(restart_age), .hit(hit)
    );

    mfd_idreg #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_idreg (
        .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(dec_shift),
        .bit_in(bit_in), .words(words)
    );

    assign exp_bit = MARK_PAT[CHK_LEN - 1 - int'(chk_q)];

    always_comb begin
        state_nx    = state_q;
        first_nx    = first_q;
        chk_nx      = chk_q;
        clr         = 1'b0;
        dec_shift   = 1'b0;
        restart     = 1'b0;
        restart_age = '0;
        report      = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (bit_valid && hit) begin
                    clr      = 1'b1;
                    state_nx = ST_PAIR_A;
                end
            end
            ST_PAIR_A: begin
                if (bit_valid) begin
                    first_nx = bit_in;
                    state_nx = ST_PAIR_B;
                end
            end
            ST_PAIR_B: begin
                if (bit_valid) begin
                    if (bit_in != first_q) begin
                        dec_shift = 1'b1;
                        state_nx  = ST_PAIR_A;
                    end else if (first_q == MARK_PAT[MARK_LEN-1]) begin
                        chk_nx   = '0;
                        state_nx = ST_CLOSE;
                    end else begin
                        restart     = 1'b1;
                        restart_age = AGE_W'(2);
                        state_nx    = ST_HUNT;
                    end
                end
            end
            ST_CLOSE: begin
                if (bit_valid) begin
                    if (bit_in == exp_bit) begin
                        if (chk_q == CHK_W'(CHK_LEN - 1)) begin
                            report   = 1'b1;
                            clr      = 1'b1;
                            state_nx = single_mode ? ST_HOLD : ST_PAIR_A;
                        end else begin
                            chk_nx = chk_q + 1'b1;
                        end
                    end else begin
                        restart     = 1'b1;
                        restart_age = AGE_W'(3) + AGE_W'(chk_q);
                        state_nx    = ST_HUNT;
                    end
                end
            end
            ST_HOLD: begin
                if (rearm) begin
                    restart  = 1'b1;
                    state_nx = ST_HUNT;
                end
            end
            default: state_nx = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            first_q <= 1'b0;
            chk_q   <= '0;
        end else begin
            state_q <= state_nx;
            first_q <= first_nx;
            chk_q   <= chk_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            out_q   <= '0;
        end else begin
            valid_q <= report;
            if (report) begin
                out_q <= words;
            end
        end
    end

    assign id_lo     = out_q[0];
    assign id_mid    = out_q[1];
    assign id_hi     = out_q[2];
    assign id_valid  = valid_q;
    assign short_fmt = (out_q[2] == '0);
    assign card_num  = out_q[0][NUM_W:1];

    // R8: the report strobe never lasts two cycles
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |=> !id_valid);
    // R4: a report always follows a completed closing check
    a_r4_from_close: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> ($past(state_q) == ST_CLOSE));
    // R10: a stopped decoder raises no strobe and stays stopped until rearm
    a_r10_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> !id_valid);
    a_r10_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && !rearm) |=> (state_q == ST_HOLD));
    // R11: with no valid bit and no rearm the controller does not move
    a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_valid && !rearm) |=> $stable(state_q));
endmodule

// File: tb/mfd_decoder_test.sv
module mfd_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] SYNC = 6'b111000;
    localparam int NVEC = 10;
    // {payload length, closer kind (0 good, 1 pair 0,0, 2 broken), payload}
    localparam logic [137:0] VECS [NVEC] = '{
        {8'd8,   2'd0, 128'hA5},
        {8'd0,   2'd0, 128'h0},
        {8'd32,  2'd0, 128'hDEADBEEF},
        {8'd40,  2'd0, 128'h12_3456_789A},
        {8'd70,  2'd0, 128'h3F_0123_4567_89AB_CDEF},
        {8'd100, 2'd0, 128'hA_BCDE_F012_3456_789A_BCDE_F012},
        {8'd16,  2'd1, 128'hBEEF},
        {8'd16,  2'd2, 128'h1234},
        {8'd1,   2'd0, 128'h1},
        {8'd17,  2'd0, 128'h1FFFE}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic single_mode = 1'b0;
    logic rearm = 1'b0;
    logic [31:0] id_hi, id_mid, id_lo;
    logic id_valid, short_fmt;
    logic [15:0] card_num;

    int checks = 0;
    int failures = 0;
    int reports = 0;
    logic [31:0] got_hi, got_mid, got_lo, first_lo;
    logic [15:0] got_card;
    logic got_short;
    bit gap_mode = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mfd_decoder uut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .single_mode(single_mode), .rearm(rearm), .id_hi(id_hi),
        .id_mid(id_mid), .id_lo(id_lo), .id_valid(id_valid),
        .short_fmt(short_fmt), .card_num(card_num)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (id_valid === 1'b1) begin
            if (reports == 0) first_lo = id_lo;
            reports++;
            got_hi = id_hi; got_mid = id_mid; got_lo = id_lo;
            got_card = card_num; got_short = short_fmt;
        end
    endtask

    task automatic send_bit(input logic b);
        bit_valid = 1'b1;
        bit_in = b;
        tick();
        bit_valid = 1'b0;
        if (gap_mode) tick();
    endtask

    task automatic send_sync();
        for (int i = 5; i >= 0; i--) send_bit(SYNC[i]);
    endtask

    task automatic send_payload(input int n, input logic [127:0] p);
        for (int i = n - 1; i >= 0; i--) begin
            if (p[i]) begin send_bit(1'b0); send_bit(1'b1); end
            else begin send_bit(1'b1); send_bit(1'b0); end
        end
    endtask

    function automatic logic [95:0] expect_id(input int n, input logic [127:0] p);
        logic [127:0] m;
        m = (n >= 128) ? '1 : ((128'd1 << n) - 128'd1);
        return 96'(p & m);
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [137:0] v;
        logic [95:0] e;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check("R12 id_valid", id_valid, 0);
        check("R12 id words", {id_hi, id_mid, id_lo}, 0);
        check("R12 short_fmt", short_fmt, 1);
        check("R12 card_num", card_num, 0);

        // Table of frames: R1 R2 R3 R4 R9
        for (int k = 0; k < NVEC; k++) begin
            v = VECS[k];
            n = int'(v[137:130]);
            reports = 0;
            send_bit(1'b0); send_bit(1'b0);
            send_sync();
            send_payload(n, v[127:0]);
            case (v[129:128])
                2'd0: begin send_sync(); send_bit(1'b0); send_bit(1'b0); end
                2'd1: begin send_bit(1'b0); send_bit(1'b0); end
                default: begin send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); end
            endcase
            check($sformatf("R4 R1 vec%0d report count", k), reports,
                  (v[129:128] == 2'd0) ? 1 : 0);
            if (v[129:128] == 2'd0) begin
                e = expect_id(n, v[127:0]);
                check($sformatf("R2 vec%0d id_lo", k), got_lo, e[31:0]);
                check($sformatf("R3 vec%0d id_mid", k), got_mid, e[63:32]);
                check($sformatf("R3 vec%0d id_hi", k), got_hi, e[95:64]);
                check($sformatf("R9 vec%0d card_num", k), got_card, e[16:1]);
                check($sformatf("R9 vec%0d short_fmt", k), got_short, (e[95:64] == 0));
            end
        end

        // R8: strobe cycle and hold
        send_bit(1'b0); send_bit(1'b0);
        send_sync();
        send_payload(2, 128'h3);
        for (int i = 5; i >= 1; i--) send_bit(SYNC[i]);
        check("R8 no early strobe", id_valid, 0);
        send_bit(SYNC[0]);
        check("R8 strobe after last closing bit", id_valid, 1);
        send_bit(1'b0);
        check("R8 strobe one cycle", id_valid, 0);
        check("R8 id held", id_lo, 32'h3);
        send_bit(1'b0);

        // R5 R6: back-to-back frames
        reports = 0;
        send_bit(1'b0); send_bit(1'b0);
        send_sync(); send_payload(8, 128'h3C);
        send_sync(); send_payload(4, 128'h5);
        send_sync(); send_bit(1'b0); send_bit(1'b0);
        check("R6 back-to-back report count", reports, 2);
        check("R6 first frame id", first_lo, 32'h3C);
        check("R5 second frame cleared id", got_lo, 32'h5);

        // R7: broken closer whose tail starts a new sync pattern
        reports = 0;
        send_bit(1'b0); send_bit(1'b0);
        send_sync(); send_payload(2, 128'h1);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
        send_payload(1, 128'h1);
        send_sync(); send_bit(1'b0); send_bit(1'b0);
        check("R7 rescan report count", reports, 1);
        check("R7 rescan id", got_lo, 32'h1);

        // R11: idle gaps between every bit
        reports = 0;
        gap_mode = 1'b1;
        send_bit(1'b0); send_bit(1'b0);
        send_sync(); send_payload(8, 128'h96);
        send_sync(); send_bit(1'b0); send_bit(1'b0);
        gap_mode = 1'b0;
        check("R11 gapped report count", reports, 1);
        check("R11 gapped id", got_lo, 32'h96);

        // R10: single-shot and rearm
        single_mode = 1'b1;
        reports = 0;
        send_bit(1'b0); send_bit(1'b0);
        send_sync(); send_payload(8, 128'h81);
        send_sync(); send_payload(8, 128'h42);
        send_sync(); send_bit(1'b0); send_bit(1'b0);
        check("R10 single-shot report count", reports, 1);
        check("R10 single-shot id", got_lo, 32'h81);
        check("R10 outputs held while stopped", id_lo, 32'h81);
        rearm = 1'b1;
        tick();
        rearm = 1'b0;
        reports = 0;
        send_bit(1'b0); send_bit(1'b0);
        send_sync(); send_payload(8, 128'h42);
        send_sync();
        check("R10 report after rearm", reports, 1);
        check("R10 id after rearm", got_lo, 32'h42);
        single_mode = 1'b0;
        rearm = 1'b1;
        tick();
        rearm = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule